// File: doc/BRIEF.md
# USB Full-Speed Suspend and Resume Controller

This block supervises the power state of a full-speed USB device. It samples the D+ and D- lines through two-flop synchronisers on a 1 µs tick. It records any bus activity in a sticky flag that software clears by writing a zero. When the bus has been idle for the suspend interval, it requests suspend. After software confirms with a sleep request, it raises a one-cycle wake interrupt when the bus comes back.

Software leaves the suspended or sleeping state in one of two ways. Bus activity brings the device back. Alternatively, software asks for a remote-wake resume. In that case the block drives the idle J state for one tick and then the K state for a programmable number of milliseconds. It then releases the line drivers and pulses a completion output.

The tick divider, the idle interval and the tick count per millisecond are parameters. The defaults suit a 250 MHz clock, a 3 ms idle interval and a 1 ms time base.

Top module: `usb_suspend_ctl`

## Requirements
- R1: After reset, tx_en, suspend_req, act_flag, wake_irq and resume_done are all 0.
- R2: On each tick, if the synchronised pair {dp,dm} differs from the idle J code 2'b10 while tx_en is 0, act_flag becomes 1 at the next edge and stays 1.
- R3: A flag_wr with flag_wr_data=0 clears act_flag. A flag_wr with flag_wr_data=1 has no effect. An activity event in the same cycle wins over the clear.
- R4: In the active state, suspend_req rises after IDLE_TICKS consecutive ticks with no activity. Every activity event restarts this count.
- R5: Activity while suspended (not sleeping) drops suspend_req at the next edge, and the idle count starts again from zero.
- R6: sleep_req is accepted only while suspended. wake_irq is high only while asleep with wake_en=1, and it lasts one cycle, raised by a tick with activity or by synchronised D+ low. The device is then active and suspend_req is 0. With wake_en=0, the device stays asleep.
- R7: If D+ is low when sleep is entered, wake_irq asserts within the first cycles of sleep without waiting for a tick.
- R8: resume_req is ignored, and tx_en stays 0, unless the device is suspended or asleep.
- R9: An accepted resume drives J (tx_en=1, tx_dat=1) for exactly TICK_DIV clocks. It then drives K (tx_en=1, tx_dat=0) for resume_ms×TICKS_PER_MS ticks, and then sets tx_en to 0.
- R10: A resume_ms value of 0 is treated as 1 ms.
- R11: resume_done pulses for one cycle, in the first cycle with tx_en back at 0. The device is then active and suspend_req is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dp_in | input | 1 | Sampled D+ line |
| dm_in | input | 1 | Sampled D- line |
| sleep_req | input | 1 | Strobe: enter sleep (accepted while suspended) |
| wake_en | input | 1 | Wake interrupt enable |
| flag_wr | input | 1 | Write strobe to the activity flag |
| flag_wr_data | input | 1 | Write data; 0 clears the flag |
| resume_req | input | 1 | Strobe: start a remote-wake resume |
| resume_ms | input | 4 | K-state duration in ms (0 clamps to 1) |
| act_flag | output | 1 | Sticky bus-activity flag |
| suspend_req | output | 1 | High while suspended or asleep |
| tx_en | output | 1 | Manual line-drive enable |
| tx_dat | output | 1 | Manual drive data: 1 = J, 0 = K |
| wake_irq | output | 1 | One-cycle wake interrupt while asleep |
| resume_done | output | 1 | One-cycle pulse when the bus is released |

## Verification
The assertions check the following on every cycle:
- A resume drive always opens with J.
- K always follows J after exactly one tick.
- wake_irq lasts one cycle and only when suspend_req is high.
- Sleep is entered only from the suspended state.
- resume_done appears only as tx_en falls.
- The idle counter stays within bounds.

Only the bench scenarios can show the following:
- The exact idle length before suspend.
- The measured J and K lengths for several resume_ms values, including the clamped zero.
- That a write of 1 leaves the flag untouched.
- That a disabled wake interrupt keeps the device asleep.
- The immediate wake when D+ is low at sleep entry.

// File: rtl/usb_susp_pkg.sv
package usb_susp_pkg;

  typedef enum logic [1:0] {
    ST_ACTIVE    = 2'd0,
    ST_SUSPENDED = 2'd1,
    ST_ASLEEP    = 2'd2,
    ST_RESUMING  = 2'd3
  } pwr_state_e;

  typedef enum logic [1:0] {
    DRV_OFF = 2'd0,
    DRV_J   = 2'd1,
    DRV_K   = 2'd2
  } drv_phase_e;

  // Resume length in ms, forced into 1..15
  function automatic logic [3:0] clamp_resume_ms(input logic [3:0] ms);
    return (ms == 4'd0) ? 4'd1 : ms;
  endfunction

  // Full-speed idle (J): D+ high, D- low
  function automatic logic pair_is_idle(input logic dp, input logic dm);
    return dp & ~dm;
  endfunction

  function automatic bit is_low_power(input pwr_state_e s);
    return (s == ST_SUSPENDED) || (s == ST_ASLEEP);
  endfunction

endpackage

// File: rtl/usb_tick_gen.sv
module usb_tick_gen #(
  parameter int TICK_DIV = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int TW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [TW-1:0] LAST = TW'(TICK_DIV - 1);

  logic [TW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (restart)    cnt_q <= '0;
    else if (tick)       cnt_q <= '0;
    else                 cnt_q <= cnt_q + TW'(1);
  end

  AST_TICK_RANGE: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= LAST); // R9
endmodule

// File: rtl/usb_bus_watch.sv
module usb_bus_watch
  import usb_susp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic dp_in,
  input  logic dm_in,
  input  logic tick,
  input  logic driving,
  input  logic flag_wr,
  input  logic flag_wr_data,
  output logic dp_sync,
  output logic act_evt,
  output logic act_flag
);
  logic [1:0] dp_pipe, dm_pipe;
  logic       flag_q;
  logic       clear_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_pipe <= 2'b11;
      dm_pipe <= 2'b00;
    end else begin
      dp_pipe <= {dp_pipe[0], dp_in};
      dm_pipe <= {dm_pipe[0], dm_in};
    end
  end

  assign dp_sync   = dp_pipe[1];
  assign act_evt   = tick & ~driving & ~pair_is_idle(dp_pipe[1], dm_pipe[1]);
  assign clear_req = flag_wr & ~flag_wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flag_q <= 1'b0;
    else if (act_evt)    flag_q <= 1'b1;
    else if (clear_req)  flag_q <= 1'b0;
  end

  assign act_flag = flag_q;

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n) act_evt |=> act_flag); // R2
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (act_flag && !clear_req) |=> act_flag); // R3
  AST_FLAG_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(act_flag) |-> $past(act_evt)); // R2
endmodule

// File: rtl/usb_idle_timer.sv
module usb_idle_timer #(
  parameter int IDLE_TICKS = 3000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  input  logic act_evt,
  output logic expire
);
  localparam int IW = $clog2(IDLE_TICKS + 1);
  localparam logic [IW-1:0] LAST = IW'(IDLE_TICKS - 1);

  logic [IW-1:0] cnt_q;

  assign expire = run & tick & ~act_evt & (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run || act_evt) cnt_q <= '0;
    else if (tick)           cnt_q <= cnt_q + IW'(1);
  end

  AST_IDLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= IW'(IDLE_TICKS)); // R4
  AST_IDLE_RESTART: assert property (@(posedge clk) disable iff (!rst_n) (run && act_evt) |=> !expire); // R4
endmodule

// File: rtl/usb_resume_seq.sv
module usb_resume_seq
  import usb_susp_pkg::*;
#(
  parameter int TICKS_PER_MS = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       tick,
  input  logic [3:0] k_ms,
  output logic       tx_en,
  output logic       tx_dat,
  output logic       seq_end,
  output logic       resume_done
);
  localparam int KW = $clog2(15 * TICKS_PER_MS + 1);

  drv_phase_e    phase_q;
  logic [KW-1:0] k_ticks_q, k_cnt_q;
  logic          en_q, dat_q, done_q;

  function automatic logic [KW-1:0] ms_to_ticks(input logic [3:0] ms);
    return KW'(int'(clamp_resume_ms(ms)) * TICKS_PER_MS);
  endfunction

  assign seq_end = (phase_q == DRV_K) && tick && (k_cnt_q == k_ticks_q - KW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= DRV_OFF;
      k_ticks_q <= '0;
      k_cnt_q   <= '0;
      en_q      <= 1'b0;
      dat_q     <= 1'b1;
      done_q    <= 1'b0;
    end else begin
      done_q <= seq_end;
      if (start) begin
        phase_q   <= DRV_J;
        k_ticks_q <= ms_to_ticks(k_ms);
        en_q      <= 1'b1;
        dat_q     <= 1'b1;
      end else begin
        case (phase_q)
          DRV_J: if (tick) begin
            phase_q <= DRV_K;
            dat_q   <= 1'b0;
            k_cnt_q <= '0;
          end
          DRV_K: if (tick) begin
            if (seq_end) begin
              phase_q <= DRV_OFF;
              en_q    <= 1'b0;
              dat_q   <= 1'b1;
            end else begin
              k_cnt_q <= k_cnt_q + KW'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign tx_en       = en_q;
  assign tx_dat      = dat_q;
  assign resume_done = done_q;

  AST_J_FIRST: assert property (@(posedge clk) disable iff (!rst_n) $rose(tx_en) |-> tx_dat); // R9
  AST_J_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n) (phase_q == DRV_J && tick && !start) |=> (tx_en && !tx_dat)); // R9
  AST_K_BOUND: assert property (@(posedge clk) disable iff (!rst_n) (phase_q == DRV_K) |-> (k_cnt_q < k_ticks_q)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) resume_done |=> !resume_done); // R11
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) resume_done |-> (!tx_en && $past(tx_en))); // R11
endmodule

// File: rtl/usb_suspend_ctl.sv
module usb_suspend_ctl
  import usb_susp_pkg::*;
#(
  parameter int TICK_DIV     = 250,
  parameter int IDLE_TICKS   = 3000,
  parameter int TICKS_PER_MS = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dp_in,
  input  logic       dm_in,
  input  logic       sleep_req,
  input  logic       wake_en,
  input  logic       flag_wr,
  input  logic       flag_wr_data,
  input  logic       resume_req,
  input  logic [3:0] resume_ms,
  output logic       act_flag,
  output logic       suspend_req,
  output logic       tx_en,
  output logic       tx_dat,
  output logic       wake_irq,
  output logic       resume_done
);
  pwr_state_e state_q, state_d;
  logic tick, act_evt, dp_sync, idle_expire, rs_start, rs_end, wake_cond;

  assign rs_start = resume_req & is_low_power(state_q);

  usb_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(rs_start), .tick(tick)
  );

  usb_bus_watch u_watch (
    .clk(clk), .rst_n(rst_n), .dp_in(dp_in), .dm_in(dm_in), .tick(tick),
    .driving(tx_en), .flag_wr(flag_wr), .flag_wr_data(flag_wr_data),
    .dp_sync(dp_sync), .act_evt(act_evt), .act_flag(act_flag)
  );

  usb_idle_timer #(.IDLE_TICKS(IDLE_TICKS)) u_idle (
    .clk(clk), .rst_n(rst_n), .run(state_q == ST_ACTIVE), .tick(tick),
    .act_evt(act_evt), .expire(idle_expire)
  );

  usb_resume_seq #(.TICKS_PER_MS(TICKS_PER_MS)) u_resume (
    .clk(clk), .rst_n(rst_n), .start(rs_start), .tick(tick), .k_ms(resume_ms),
    .tx_en(tx_en), .tx_dat(tx_dat), .seq_end(rs_end), .resume_done(resume_done)
  );

  assign wake_cond = ~dp_sync | act_evt;
  assign wake_irq  = (state_q == ST_ASLEEP) & wake_en & wake_cond;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_ACTIVE:    if (idle_expire) state_d = ST_SUSPENDED;
      ST_SUSPENDED: begin
        if (rs_start)       state_d = ST_RESUMING;
        else if (act_evt)   state_d = ST_ACTIVE;
        else if (sleep_req) state_d = ST_ASLEEP;
      end
      ST_ASLEEP: begin
        if (rs_start)      state_d = ST_RESUMING;
        else if (wake_irq) state_d = ST_ACTIVE;
      end
      ST_RESUMING:  if (rs_end) state_d = ST_ACTIVE;
      default:      state_d = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_ACTIVE;
    else        state_q <= state_d;
  end

  assign suspend_req = is_low_power(state_q);

  AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) wake_irq |=> !wake_irq); // R6
  AST_WAKE_WHILE_SUSP: assert property (@(posedge clk) disable iff (!rst_n) wake_irq |-> suspend_req); // R6
  AST_WAKE_LEAVES: assert property (@(posedge clk) disable iff (!rst_n) (wake_irq && !resume_req) |=> !suspend_req); // R6
  AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_ASLEEP && $past(state_q) != ST_ASLEEP) |-> $past(state_q) == ST_SUSPENDED); // R6
  AST_SUSP_DROP: assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_SUSPENDED && act_evt && !resume_req) |=> !suspend_req); // R5
  AST_RESUME_GATE: assert property (@(posedge clk) disable iff (!rst_n) $rose(tx_en) |-> $past(suspend_req)); // R8
  AST_DRIVE_STATE: assert property (@(posedge clk) disable iff (!rst_n) tx_en |-> (state_q == ST_RESUMING)); // R9
endmodule

// File: tb/sim_usb_suspend_ctl.sv
`timescale 1ns/1ps
module sim_usb_suspend_ctl;
  localparam int DIV = 2, IDLE = 30, TPM = 10;

  logic clk = 0, rst_n = 0;
  logic dp_in = 1, dm_in = 0, sleep_req = 0, wake_en = 0, flag_wr = 0, flag_wr_data = 0, resume_req = 0;
  logic [3:0] resume_ms = 0;
  logic act_flag, suspend_req, tx_en, tx_dat, wake_irq, resume_done;
  int checks = 0, fails = 0, wake_seen = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  usb_suspend_ctl #(.TICK_DIV(DIV), .IDLE_TICKS(IDLE), .TICKS_PER_MS(TPM)) u0 (
    .clk(clk), .rst_n(rst_n), .dp_in(dp_in), .dm_in(dm_in), .sleep_req(sleep_req),
    .wake_en(wake_en), .flag_wr(flag_wr), .flag_wr_data(flag_wr_data),
    .resume_req(resume_req), .resume_ms(resume_ms), .act_flag(act_flag),
    .suspend_req(suspend_req), .tx_en(tx_en), .tx_dat(tx_dat), .wake_irq(wake_irq),
    .resume_done(resume_done));

  // Behavioural reference: mode 0 active, 1 suspended, 2 asleep, 3 resuming
  int m_tc, m_idle, m_mode, m_ph, m_kc, m_kt;
  bit m_p1, m_p2, m_m1, m_m2, m_flag, m_txe, m_txd, m_done;

  function automatic bit m_tick(); return m_tc == DIV - 1; endfunction
  function automatic bit m_act(); return m_tick() && !(m_p2 == 1 && m_m2 == 0) && !m_txe; endfunction
  function automatic bit m_wake(); return m_mode == 2 && wake_en && (!m_p2 || m_act()); endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tc = 0; m_idle = 0; m_mode = 0; m_ph = 0; m_kc = 0; m_kt = 0;
      m_p1 = 1; m_p2 = 1; m_m1 = 0; m_m2 = 0; m_flag = 0; m_txe = 0; m_txd = 1; m_done = 0;
    end else begin
      automatic bit tk = m_tick(), ev = m_act(), wk = m_wake();
      automatic bit go = resume_req && (m_mode == 1 || m_mode == 2);
      automatic bit fin = (m_ph == 2) && tk && (m_kc + 1 == m_kt);
      automatic bit exp = (m_mode == 0) && tk && !ev && (m_idle + 1 == IDLE);
      automatic int nm = m_mode;
      if (m_mode == 0 && exp) nm = 1;
      else if (m_mode == 1) nm = go ? 3 : ev ? 0 : sleep_req ? 2 : 1;
      else if (m_mode == 2) nm = go ? 3 : wk ? 0 : 2;
      else if (m_mode == 3 && fin) nm = 0;
      if (ev) m_flag = 1; else if (flag_wr && !flag_wr_data) m_flag = 0;
      m_idle = (m_mode != 0 || ev) ? 0 : (tk ? m_idle + 1 : m_idle);
      m_done = fin;
      if (go) begin
        m_ph = 1; m_txe = 1; m_txd = 1; m_kt = (resume_ms < 1 ? 1 : int'(resume_ms)) * TPM;
      end else if (m_ph == 1 && tk) begin
        m_ph = 2; m_txd = 0; m_kc = 0;
      end else if (m_ph == 2 && tk) begin
        if (fin) begin m_ph = 0; m_txe = 0; m_txd = 1; end else m_kc++;
      end
      m_tc = (go || tk) ? 0 : m_tc + 1;
      m_p2 = m_p1; m_p1 = dp_in; m_m2 = m_m1; m_m1 = dm_in;
      m_mode = nm;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    check(act_flag == m_flag, "R2 act_flag vs model", act_flag, m_flag);
    check(suspend_req == (m_mode == 1 || m_mode == 2), "R4 suspend_req vs model", suspend_req, int'(m_mode == 1 || m_mode == 2));
    check(tx_en == m_txe, "R9 tx_en vs model", tx_en, m_txe);
    if (tx_en) check(tx_dat == m_txd, "R9 tx_dat vs model", tx_dat, m_txd);
    check(wake_irq == m_wake(), "R6 wake_irq vs model", wake_irq, m_wake());
    check(resume_done == m_done, "R11 resume_done vs model", resume_done, m_done);
    if (wake_irq) wake_seen++;
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic line(input bit p, input bit m);
    dp_in = p; dm_in = m;
  endtask

  task automatic wait_susp();
    for (int i = 0; i < 400 && !suspend_req; i++) step(1);
  endtask

  task automatic do_resume(input logic [3:0] ms, input int exp_k, input string tag);
    int jc = 0, kc = 0;
    bit done_ok = 0;
    resume_ms = ms; resume_req = 1; step(1); resume_req = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (tx_en && tx_dat) jc++;
      else if (tx_en && !tx_dat) kc++;
      else begin done_ok = resume_done && !suspend_req; break; end
    end
    check(jc == DIV, {tag, " J length"}, jc, DIV);
    check(kc == exp_k, {tag, " K length"}, kc, exp_k);
    check(done_ok, "R11 done pulse at release", done_ok, 1);
    @(negedge clk);
    check(!resume_done, "R11 done is one cycle", resume_done, 0);
    #1;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    step(3);
    @(negedge clk);
    check(!tx_en && !suspend_req && !act_flag && !wake_irq && !resume_done, "R1 reset outputs", tx_en, 0);
    rst_n = 1; step(1);
    // R2: short K burst sets the sticky flag
    line(0, 1); step(4); line(1, 0); step(6);
    check(act_flag, "R2 flag after activity", act_flag, 1);
    // R3: writing 1 keeps, writing 0 clears
    flag_wr = 1; flag_wr_data = 1; step(1); flag_wr = 0; step(1);
    check(act_flag, "R3 write one ignored", act_flag, 1);
    flag_wr = 1; flag_wr_data = 0; step(1); flag_wr = 0; step(1);
    check(!act_flag, "R3 write zero clears", act_flag, 0);
    // R4: idle interval
    step(20);
    check(!suspend_req, "R4 not yet idle long enough", suspend_req, 0);
    step(60);
    check(suspend_req, "R4 suspend after idle", suspend_req, 1);
    // R5: activity while suspended
    line(0, 0); step(6); line(1, 0);
    check(!suspend_req, "R5 activity ends suspend", suspend_req, 0);
    // R8: resume ignored when active
    resume_req = 1; step(1); resume_req = 0; step(4);
    check(!tx_en, "R8 resume ignored in active", tx_en, 0);
    // R6: sleep, then wake on activity
    wait_susp(); wake_en = 1; sleep_req = 1; step(1); sleep_req = 0; step(10);
    check(suspend_req && wake_seen == 0, "R6 asleep on idle bus", wake_seen, 0);
    line(0, 1); step(8); line(1, 0);
    check(wake_seen == 1 && !suspend_req, "R6 wake on activity", wake_seen, 1);
    // R7: D+ low at sleep entry
    wait_susp(); wake_seen = 0; sleep_req = 1; line(0, 0); step(1); sleep_req = 0; step(5); line(1, 0);
    check(wake_seen == 1, "R7 immediate wake", wake_seen, 1);
    // R6: wake disabled keeps sleeping; then resume from sleep
    wait_susp(); wake_en = 0; wake_seen = 0; sleep_req = 1; step(1); sleep_req = 0;
    line(0, 1); step(10); line(1, 0); step(4);
    check(suspend_req && wake_seen == 0, "R6 no wake when disabled", suspend_req, 1);
    do_resume(4'd3, 3 * TPM * DIV, "R9");
    // R10: zero clamps to one ms, from suspended state
    wait_susp();
    do_resume(4'd0, TPM * DIV, "R10");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule